// File: doc/BRIEF.md
# Half-Bridge Gate Command Logic with Dead Time

This block sits between a PWM generator and the two gate drivers of a half bridge. It takes a high-side command and a low-side command and produces a registered, glitch-free gate enable for each side. Each gate follows its own command, with no inversion.

The block protects the bridge in three ways:

- **Interlock.** It refuses to turn both switches on together.
- **Dead time.** After one gate drops, it holds the opposite gate off for a programmable number of clock cycles.
- **Undervoltage lockout.** It watches two supply levels, given as unsigned millivolt codes. One is the main supply. The other is the floating supply of the high-side driver.

A lockout on the main supply silences everything. A lockout on the floating supply only silences the high side. A bootstrap-charge enable output mirrors the low-side gate, so the floating capacitor is refilled whenever the low switch conducts.

The commands pass through a two-stage synchronizer. The supply codes are taken as synchronous to the clock. At the default of 32 cycles and a 100 MHz clock, the dead time is 320 ns.

Top module: `hb_gate_core`

## Requirements
- R1: After reset, `gate_hi`, `gate_lo` and `boot_en` are 0, and both lockouts are active. No gate turns on until the supplies qualify.
- R2: With supplies qualified and no conflict, each gate follows its own command in phase. A command change on the input shows on the gate at the third rising clock edge after it is applied (two synchronizer flops plus the output register).
- R3: While both synchronized commands are 1, both gates are driven to 0 at the next edge.
- R4: After either gate falls, the opposite gate stays 0 for exactly `DT_CYCLES` clock cycles. When its command is held throughout, it rises on the `DT_CYCLES`-th rising edge after the fall.
- R5: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R6: A request for the opposite gate that is withdrawn before the dead-time count expires is dropped. That gate never rises for it.
- R7: The main lockout releases when `vmain_mv` is 9600 or more. It re-asserts when `vmain_mv` is below 8300. Codes in between leave it unchanged. The flag updates at the edge that samples the code, and the gates respond one edge later.
- R8: The floating lockout releases at `vfloat_mv` of 9500 or more and re-asserts below 8200, with a hold band in between. While it is active, only `gate_hi` is forced to 0, and `gate_lo` is unaffected.
- R9: While the main lockout is active, `gate_hi`, `gate_lo` and `boot_en` are all 0.
- R10: `boot_en` equals `gate_lo` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | 1 | High-side PWM command, 1 requests the high gate on |
| cmd_lo | input | 1 | Low-side PWM command, 1 requests the low gate on |
| vmain_mv | input | SUPPLY_W | Main supply level in millivolts, unsigned |
| vfloat_mv | input | SUPPLY_W | Floating high-side supply level in millivolts, unsigned |
| gate_hi | output | 1 | Registered high-side gate enable |
| gate_lo | output | 1 | Registered low-side gate enable |
| boot_en | output | 1 | Bootstrap charge enable, tracks `gate_lo` |

## Verification
The lockout properties take the supply codes to be synchronous and stable across each sampling edge. The stimulus satisfies this by changing the codes only at the falling edge. The dead-time properties assume that a gate can only rise from an idle state, so the gap they measure starts at the opposite gate's fall. The random stimulus holds each command pattern for a random 1 to 60 cycles, which spans both sides of the 32-cycle dead time. The supply codes mostly stay well clear of the thresholds, with occasional dips through the hysteresis band. Directed sequences step each threshold code and its neighbour exactly.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Side whose turn-on is currently held back by the dead-time counter.
  typedef enum logic {
    SIDE_HI = 1'b0,
    SIDE_LO = 1'b1
  } hb_side_e;

  // Hysteretic lockout update: an active flag clears only above the release
  // level, an inactive flag sets only below the trip level.
  function automatic logic uv_step(input logic uv_now,
                                   input logic at_or_above_release,
                                   input logic below_trip);
    logic nxt;
    if (uv_now) nxt = !at_or_above_release;
    else        nxt = below_trip;
    return nxt;
  endfunction

  // A gate may turn on when requested, the other gate is off, and the
  // dead-time counter is not holding this particular side.
  function automatic logic gate_permit(input logic req,
                                       input logic other_on,
                                       input logic dt_busy,
                                       input logic held_side);
    return req & ~other_on & ~(dt_busy & held_side);
  endfunction

  // Exclusive request decode: one command alone and no blocking lockout.
  function automatic logic solo_request(input logic mine,
                                        input logic theirs,
                                        input logic locked);
    return mine & ~theirs & ~locked;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din[b]};
    end

    assign dout[b] = chain_q[LAST];
  end

endmodule

// File: rtl/hb_uvlo.sv
module hb_uvlo #(
  parameter int unsigned         W        = 16,
  parameter logic [W-1:0]        RELEASE  = 16'd9600,
  parameter logic [W-1:0]        TRIP     = 16'd8300
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic         uv_flag
);
  import hb_pkg::*;

  logic above_release;
  logic below_trip;
  logic uv_q;

  assign above_release = (level >= RELEASE);
  assign below_trip    = (level < TRIP);

  // Lockout is asserted out of reset; only a qualifying level clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uv_q <= 1'b1;
    else        uv_q <= uv_step(uv_q, above_release, below_trip);
  end

  assign uv_flag = uv_q;

  // R7 (main instance) and R8 (floating instance): thresholds and hold band
  a_r7_release : assert property (@(posedge clk) disable iff (!rst_n)
    (level >= RELEASE) |=> !uv_flag);

  a_r7_trip : assert property (@(posedge clk) disable iff (!rst_n)
    (level < TRIP) |=> uv_flag);

  a_r7_band_hold : assert property (@(posedge clk) disable iff (!rst_n)
    ((level >= TRIP) && (level < RELEASE)) |=> $stable(uv_flag));

endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime #(
  parameter int unsigned DT_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hi,
  input  logic req_lo,
  output logic gate_hi,
  output logic gate_lo,
  output logic gate_lo_nxt
);
  import hb_pkg::*;

  localparam int unsigned      CNT_W  = $clog2(DT_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DT_CYCLES - 1);
  localparam logic [CNT_W-1:0] SAT    = CNT_W'(DT_CYCLES);

  logic             hi_q, lo_q;
  logic [CNT_W-1:0] cnt_q;
  hb_side_e         held_q;

  logic dt_busy;
  logic hi_nxt, lo_nxt;
  logic hi_off_evt, lo_off_evt;

  assign dt_busy = |cnt_q;

  assign hi_nxt = gate_permit(req_hi, lo_q, dt_busy, held_q == SIDE_HI);
  assign lo_nxt = gate_permit(req_lo, hi_q, dt_busy, held_q == SIDE_LO);

  assign hi_off_evt = hi_q & ~hi_nxt;
  assign lo_off_evt = lo_q & ~lo_nxt;

  // Gate registers: outputs come straight from flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
    end
  end

  // Dead-time counter: every turn-off restarts it and holds the other side.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= SIDE_HI;
    end else if (hi_off_evt) begin
      cnt_q  <= RELOAD;
      held_q <= SIDE_LO;
    end else if (lo_off_evt) begin
      cnt_q  <= RELOAD;
      held_q <= SIDE_HI;
    end else if (dt_busy) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign gate_hi     = hi_q;
  assign gate_lo     = lo_q;
  assign gate_lo_nxt = lo_nxt;

  // Independent observers: cycles since each gate last fell, saturating.
  logic [CNT_W-1:0] hi_off_age, lo_off_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_off_age <= SAT;
      lo_off_age <= SAT;
    end else begin
      if (hi_off_evt)           hi_off_age <= '0;
      else if (hi_off_age != SAT) hi_off_age <= hi_off_age + 1'b1;
      if (lo_off_evt)           lo_off_age <= '0;
      else if (lo_off_age != SAT) lo_off_age <= lo_off_age + 1'b1;
    end
  end

  a_r4_lo_waits_dt : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> (hi_off_age >= SAT));

  a_r4_hi_waits_dt : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> (lo_off_age >= SAT));

  a_r5_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  a_r6_no_stale_lo : assert property (@(posedge clk) disable iff (!rst_n)
    !req_lo |=> !$rose(gate_lo));

  a_r6_no_stale_hi : assert property (@(posedge clk) disable iff (!rst_n)
    !req_hi |=> !$rose(gate_hi));

endmodule

// File: rtl/hb_gate_core.sv
module hb_gate_core #(
  parameter int unsigned        SUPPLY_W      = 16,
  parameter int unsigned        DT_CYCLES     = 32,
  parameter logic [SUPPLY_W-1:0] MAIN_RELEASE = 16'd9600,
  parameter logic [SUPPLY_W-1:0] MAIN_TRIP    = 16'd8300,
  parameter logic [SUPPLY_W-1:0] FLT_RELEASE  = 16'd9500,
  parameter logic [SUPPLY_W-1:0] FLT_TRIP     = 16'd8200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_hi,
  input  logic                cmd_lo,
  input  logic [SUPPLY_W-1:0] vmain_mv,
  input  logic [SUPPLY_W-1:0] vfloat_mv,
  output logic                gate_hi,
  output logic                gate_lo,
  output logic                boot_en
);
  import hb_pkg::*;

  localparam int unsigned CMD_W = 2;

  logic [CMD_W-1:0] cmd_raw, cmd_s;
  logic hi_s, lo_s;
  logic uv_main, uv_flt;
  logic req_hi, req_lo;
  logic lo_nxt;
  logic boot_q;

  assign cmd_raw = {cmd_hi, cmd_lo};

  hb_sync #(.WIDTH(CMD_W), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cmd_raw),
    .dout (cmd_s)
  );

  assign hi_s = cmd_s[1];
  assign lo_s = cmd_s[0];

  hb_uvlo #(.W(SUPPLY_W), .RELEASE(MAIN_RELEASE), .TRIP(MAIN_TRIP)) u_uv_main (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (vmain_mv),
    .uv_flag(uv_main)
  );

  hb_uvlo #(.W(SUPPLY_W), .RELEASE(FLT_RELEASE), .TRIP(FLT_TRIP)) u_uv_flt (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (vfloat_mv),
    .uv_flag(uv_flt)
  );

  // Interlock plus lockout gating of the requests.
  assign req_hi = solo_request(hi_s, lo_s, uv_main | uv_flt);
  assign req_lo = solo_request(lo_s, hi_s, uv_main);

  hb_deadtime #(.DT_CYCLES(DT_CYCLES)) u_dt (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_hi     (req_hi),
    .req_lo     (req_lo),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .gate_lo_nxt(lo_nxt)
  );

  // Bootstrap enable has its own flop, loaded in step with the low gate.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b0;
    else        boot_q <= lo_nxt;
  end

  assign boot_en = boot_q;

  a_r3_both_cmd_blocks : assert property (@(posedge clk) disable iff (!rst_n)
    (hi_s && lo_s) |=> (!gate_hi && !gate_lo));

  a_r2_hi_needs_cmd : assert property (@(posedge clk) disable iff (!rst_n)
    !hi_s |=> !gate_hi);

  a_r2_lo_needs_cmd : assert property (@(posedge clk) disable iff (!rst_n)
    !lo_s |=> !gate_lo);

  a_r9_main_lockout : assert property (@(posedge clk) disable iff (!rst_n)
    uv_main |=> (!gate_hi && !gate_lo && !boot_en));

  a_r8_float_lockout : assert property (@(posedge clk) disable iff (!rst_n)
    uv_flt |=> !gate_hi);

  a_r10_boot_tracks : assert property (@(posedge clk) disable iff (!rst_n)
    boot_en == gate_lo);

endmodule

// File: tb/hb_gate_core_test.sv
module hb_gate_core_test;

  localparam int unsigned DT  = 32;
  localparam int unsigned SW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_hi = 1'b0, cmd_lo = 1'b0;
  logic [SW-1:0] vmain_mv = '0, vfloat_mv = '0;
  logic          gate_hi, gate_lo, boot_en;

  always #2 clk = ~clk;

  hb_gate_core #(.SUPPLY_W(SW), .DT_CYCLES(DT)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .vmain_mv(vmain_mv), .vfloat_mv(vfloat_mv),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .boot_en(boot_en)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Behavioural model state, written from the requirements.
  bit m_h1, m_h2, m_l1, m_l2;
  bit m_uvm = 1, m_uvf = 1;
  bit m_gh, m_gl, m_boot;
  int m_wait = 0;
  bit m_wait_on_hi = 0;

  int cyc = 0;
  bit p_gh, p_gl;
  int fall_hi_cyc = -1, fall_lo_cyc = -1, rise_hi_cyc = -1, rise_lo_cyc = -1;
  int lo_rises = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Lockout rule restated as a threshold table walk.
  function automatic bit lock_next(bit cur, int v, int rel, int trip);
    if (v >= rel) return 0;
    if (v < trip) return 1;
    return cur;
  endfunction

  task automatic model_edge(input bit ch, input bit cl, input int vm, input int vf);
    bit want_h, want_l, nh, nl;
    want_h = m_h2 && !m_l2 && !m_uvm && !m_uvf;
    want_l = m_l2 && !m_h2 && !m_uvm;
    nh = want_h && !m_gl && !(m_wait > 0 && m_wait_on_hi);
    nl = want_l && !m_gh && !(m_wait > 0 && !m_wait_on_hi);
    if (m_gh && !nh)      begin m_wait = DT - 1; m_wait_on_hi = 0; end
    else if (m_gl && !nl) begin m_wait = DT - 1; m_wait_on_hi = 1; end
    else if (m_wait > 0)  m_wait--;
    m_gh = nh; m_gl = nl; m_boot = nl;
    m_uvm = lock_next(m_uvm, vm, 9600, 8300);
    m_uvf = lock_next(m_uvf, vf, 9500, 8200);
    m_h2 = m_h1; m_h1 = ch;
    m_l2 = m_l1; m_l1 = cl;
  endtask

  task automatic step(input bit ch, input bit cl, input int vm, input int vf);
    @(negedge clk);
    cmd_hi = ch; cmd_lo = cl;
    vmain_mv = SW'(vm); vfloat_mv = SW'(vf);
    @(posedge clk);
    #1;
    cyc++;
    model_edge(ch, cl, vm, vf);
    chk("R2/R3 gate_hi vs model", gate_hi, m_gh);
    chk("R4/R9 gate_lo vs model", gate_lo, m_gl);
    chk("R10 boot_en vs model", boot_en, m_boot);
    if (gate_hi && gate_lo) chk("R5 exclusive gates", 1'b1, 1'b0);
    if (p_gh && !gate_hi) fall_hi_cyc = cyc;
    if (!p_gh && gate_hi) rise_hi_cyc = cyc;
    if (p_gl && !gate_lo) fall_lo_cyc = cyc;
    if (!p_gl && gate_lo) begin rise_lo_cyc = cyc; lo_rises++; end
    p_gh = gate_hi; p_gl = gate_lo;
  endtask

  task automatic hold(input int n, input bit ch, input bit cl, input int vm, input int vf);
    for (int i = 0; i < n; i++) step(ch, cl, vm, vf);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_sink;
    int lo_before;
    seed_sink = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 gate_hi after reset", gate_hi, 1'b0);
    chk("R1 gate_lo after reset", gate_lo, 1'b0);
    chk("R1 boot_en after reset", boot_en, 1'b0);

    // R1/R9: supplies absent, low request ignored
    hold(10, 0, 1, 0, 0);
    chk("R1 locked at start", gate_lo, 1'b0);
    // R7: band value cannot release the lockout held from reset
    hold(10, 0, 1, 9000, 0);
    chk("R7 band keeps lockout", gate_lo, 1'b0);
    hold(5, 0, 1, 9599, 0);
    chk("R7 9599 below release", gate_lo, 1'b0);
    hold(3, 0, 1, 9600, 0);
    chk("R7 release at 9600 / R8 low side free", gate_lo, 1'b1);
    // R2: latency of a command change is three edges
    hold(2, 0, 0, 12000, 0);
    chk("R2 gate_lo after two edges", gate_lo, 1'b1);
    hold(1, 0, 0, 12000, 0);
    chk("R2 gate_lo after three edges", gate_lo, 1'b0);
    // R8 floating thresholds
    hold(40, 1, 0, 12000, 9499);
    chk("R8 9499 keeps high side off", gate_hi, 1'b0);
    hold(3, 1, 0, 12000, 9500);
    chk("R8 release at 9500", gate_hi, 1'b1);
    hold(5, 1, 0, 12000, 8200);
    chk("R8 8200 holds", gate_hi, 1'b1);
    hold(2, 1, 0, 12000, 8199);
    chk("R8 8199 trips high side", gate_hi, 1'b0);
    hold(40, 1, 0, 12000, 12000);
    chk("R2 high side on", gate_hi, 1'b1);
    // R4 both directions
    hold(60, 0, 1, 12000, 12000);
    chk_int("R4 hi fall to lo rise", rise_lo_cyc - fall_hi_cyc, DT);
    hold(60, 1, 0, 12000, 12000);
    chk_int("R4 lo fall to hi rise", rise_hi_cyc - fall_lo_cyc, DT);
    // R3 both commands
    hold(20, 1, 1, 12000, 12000);
    chk("R3 both high -> gate_hi 0", gate_hi, 1'b0);
    chk("R3 both high -> gate_lo 0", gate_lo, 1'b0);
    // R6 withdrawn request
    hold(40, 1, 0, 12000, 12000);
    lo_before = lo_rises;
    hold(10, 0, 1, 12000, 12000);
    hold(60, 0, 0, 12000, 12000);
    chk_int("R6 dropped low request", lo_rises, lo_before);
    // R7/R9 main trip while low side on
    hold(60, 0, 1, 12000, 12000);
    hold(5, 0, 1, 8300, 12000);
    chk("R7 8300 holds", gate_lo, 1'b1);
    hold(2, 0, 1, 8299, 12000);
    chk("R9 main trip clears gate_lo", gate_lo, 1'b0);
    chk("R9 main trip clears boot_en", boot_en, 1'b0);
    hold(5, 0, 1, 12000, 12000);

    // Random phase
    for (int k = 0; k < 150; k++) begin
      int len, vm, vf, pat;
      len = 1 + int'($urandom_range(59));
      pat = int'($urandom_range(3));
      vm  = ($urandom_range(9) == 0) ? 7000 + int'($urandom_range(4000)) : 12000;
      vf  = ($urandom_range(7) == 0) ? 7000 + int'($urandom_range(4000)) : 12000;
      hold(len, pat[1], pat[0], vm, vf);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule